// File: doc/BRIEF.md
# Configurable Two-Plane Logic Array

This block is a sum-of-products logic array in which both the AND plane and the OR plane are set by configuration. A vector of routed signals enters the array. Each signal is offered as two literals, its true form and its inverted form. Every product term ANDs any chosen set of those literals. Every summed output ORs any chosen set of product terms. Because the OR plane is programmable, product terms are shared freely between outputs. No output owns a fixed group of terms.

Two groups of terms have a second role. The first few terms can be claimed as control terms, which are exported on their own port for use as clocks, resets, presets or enables. The last few terms can be enabled as foldback terms. An enabled foldback term is inverted (NAND form) and fed back into the AND plane as an extra literal, so wider functions can be built in two levels. A term that is not claimed for its special role stays an ordinary product term for the OR plane.

The configuration is shifted in serially into a shadow register. A load strobe copies it into the active register in one cycle, so the logic never sees a half-written pattern. The outputs are combinational functions of the inputs and the active configuration.

Top module: `pla_array`

## Requirements
- R1: After reset the active configuration is all zero: every output in `out_o` and `ct_o` is 0 and every bit of `fb_o` is 1, whatever the inputs are.
- R2: A product term is 1 when every literal selected in its row is 1. A term with no literal selected is 1. Literal 2i is input i, and literal 2i+1 is the inverse of input i.
- R3: Summed output o is the OR of the selected product terms that are eligible. An output with no eligible term selected is 0.
- R4: Term c, for c < N_CT, is a control term. With its claim bit set, `ct_o[c]` equals the term and the term is left out of the OR plane. With the claim bit clear, `ct_o[c]` is 0 and the term is an ordinary OR-plane term.
- R5: Term N_PT-N_FB+k is foldback term k. With its enable bit set, `fb_o[k]` is the inverse of the term, the term is left out of the OR plane, and `fb_o[k]` is offered to the non-foldback terms as literal 2*N_IN+k.
- R6: With foldback k disabled, `fb_o[k]` is 1. Selecting literal 2*N_IN+k then has no effect, and the term is an ordinary OR-plane term.
- R7: While `cfg_shift_en` is high, one bit per cycle enters the top of the shadow register and the shadow moves down by one place. After the full length has been shifted, the first bit sent sits at index 0. Shifting never changes the outputs.
- R8: A `cfg_load` high at a clock edge copies the whole shadow into the active configuration at that edge. When shift and load are high in the same cycle, the contents from before the shift are loaded.
- R9: Layout of the configuration vector: row p of the AND plane starts at p*(2*N_IN+N_FB), and its bit l selects literal l. OR row o starts at N_PT*(2*N_IN+N_FB)+o*N_PT, and its bit p selects term p. Next come N_CT claim bits, then N_FB foldback enable bits.
- R10: A foldback term uses only the 2*N_IN input literals. Foldback-literal bits in its own row have no effect, so no configuration can form a loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Shifts `cfg_bit` into the shadow register |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copies the shadow into the active configuration |
| in_i | input | N_IN | Routed array inputs |
| out_o | output | N_OUT | Summed logic outputs |
| ct_o | output | N_CT | Claimed control terms |
| fb_o | output | N_FB | Foldback terms in NAND form (1 when disabled) |

## Verification
The hardest case to reach from the ports is a foldback term that feeds a non-foldback term. A wrong path there only shows when the foldback term is enabled, its own inputs make it true, and the downstream term also selects other live literals. Random sparse configurations almost never line this up. A directed configuration therefore wires one enabled foldback term into a term that also selects a plain input. It also sets the self-referencing bits that must be ignored. The test then walks the inputs through the combinations that separate NAND, AND and pass-through behaviour. A second hard case is a load strobe in the same cycle as a shift. The bench shifts a pattern one bit short, raises both strobes together, and then loads again, so that the pre-shift and post-shift contents show up at the outputs one after the other.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // width of one AND-plane row: true and inverted inputs, then foldback literals
  function automatic int row_width(input int n_in, input int n_fb);
    return 2 * n_in + n_fb;
  endfunction

  // first bit of OR row o
  function automatic int or_row_base(input int n_pt, input int lw, input int o);
    return n_pt * lw + o * n_pt;
  endfunction

  // first claim bit
  function automatic int claim_base(input int n_pt, input int lw, input int n_out);
    return n_pt * lw + n_out * n_pt;
  endfunction

  // first foldback enable bit
  function automatic int fben_base(input int n_pt, input int lw, input int n_out,
                                   input int n_ct);
    return claim_base(n_pt, lw, n_out) + n_ct;
  endfunction

  // whole configuration length
  function automatic int cfg_len(input int n_in, input int n_pt, input int n_ct,
                                 input int n_fb, input int n_out);
    return fben_base(n_pt, row_width(n_in, n_fb), n_out, n_ct) + n_fb;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_i,
  input  logic         load,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shift_en) shadow_q <= {bit_i, shadow_q[W-1:1]};
      if (load)     active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int NT = 4,
  parameter int NL = 8
) (
  input  logic [NL-1:0]    lit_i,
  input  logic [NT*NL-1:0] mask_i,
  output logic [NT-1:0]    term_o
);
  for (genvar t = 0; t < NT; t++) begin : g_term
    // an unselected literal is forced to 1, so an empty row gives 1
    assign term_o[t] = &(lit_i | ~mask_i[t*NL +: NL]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NT = 4,
  parameter int NO = 2
) (
  input  logic [NT-1:0]    term_i,
  input  logic [NT-1:0]    usable_i,
  input  logic [NO*NT-1:0] sel_i,
  output logic [NO-1:0]    out_o
);
  for (genvar o = 0; o < NO; o++) begin : g_out
    assign out_o[o] = |(term_i & usable_i & sel_i[o*NT +: NT]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN  = 36,
  parameter int N_PT  = 48,
  parameter int N_CT  = 8,
  parameter int N_FB  = 8,
  parameter int N_OUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift_en,
  input  logic             cfg_bit,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o,
  output logic [N_CT-1:0]  ct_o,
  output logic [N_FB-1:0]  fb_o
);
  localparam int LW     = row_width(N_IN, N_FB);
  localparam int NL_FB  = 2 * N_IN;
  localparam int N_MAIN = N_PT - N_FB;
  localparam int ORB    = or_row_base(N_PT, LW, 0);
  localparam int CLB    = claim_base(N_PT, LW, N_OUT);
  localparam int FEB    = fben_base(N_PT, LW, N_OUT, N_CT);
  localparam int TOT    = cfg_len(N_IN, N_PT, N_CT, N_FB, N_OUT);

  logic [TOT-1:0]         shadow_w;
  logic [TOT-1:0]         active_w;
  logic [NL_FB-1:0]       lit_w;
  logic [N_FB*NL_FB-1:0]  fb_mask_w;
  logic [N_FB-1:0]        fb_and_w;
  logic [N_FB-1:0]        fb_lit_w;
  logic [N_MAIN-1:0]      main_term_w;
  logic [N_PT-1:0]        term_w;
  logic [N_PT-1:0]        usable_w;
  logic [N_OUT*N_PT-1:0]  or_sel_w;
  logic [N_CT-1:0]        claim_w;
  logic [N_FB-1:0]        fb_en_w;
  logic [N_OUT-1:0]       or_nonempty_w;

  pla_cfg_store #(.W(TOT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift_en),
    .bit_i    (cfg_bit),
    .load     (cfg_load),
    .shadow_o (shadow_w),
    .active_o (active_w)
  );

  // literal 2i = input i, literal 2i+1 = its inverse
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_w[2*i]   = in_i[i];
    assign lit_w[2*i+1] = ~in_i[i];
  end

  assign or_sel_w = active_w[ORB +: N_OUT*N_PT];
  assign claim_w  = active_w[CLB +: N_CT];
  assign fb_en_w  = active_w[FEB +: N_FB];

  // foldback rows only see input literals: their foldback-literal bits are dropped
  for (genvar k = 0; k < N_FB; k++) begin : g_fbmask
    assign fb_mask_w[k*NL_FB +: NL_FB] = active_w[(N_MAIN+k)*LW +: NL_FB];
    assign fb_lit_w[k] = fb_en_w[k] ? ~fb_and_w[k] : 1'b1;
  end

  pla_and_plane #(.NT(N_FB), .NL(NL_FB)) u_fb_and (
    .lit_i  (lit_w),
    .mask_i (fb_mask_w),
    .term_o (fb_and_w)
  );

  pla_and_plane #(.NT(N_MAIN), .NL(LW)) u_main_and (
    .lit_i  ({fb_lit_w, lit_w}),
    .mask_i (active_w[N_MAIN*LW-1:0]),
    .term_o (main_term_w)
  );

  assign term_w = {fb_and_w, main_term_w};

  // a term enters the OR plane unless it is claimed for its special role
  for (genvar p = 0; p < N_PT; p++) begin : g_use
    if (p < N_CT) begin : g_ct
      assign usable_w[p] = ~claim_w[p];
    end else if (p >= N_MAIN) begin : g_fb
      assign usable_w[p] = ~fb_en_w[p-N_MAIN];
    end else begin : g_plain
      assign usable_w[p] = 1'b1;
    end
  end

  pla_or_plane #(.NT(N_PT), .NO(N_OUT)) u_or (
    .term_i   (term_w),
    .usable_i (usable_w),
    .sel_i    (or_sel_w),
    .out_o    (out_o)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_ne
    assign or_nonempty_w[o] = |or_sel_w[o*N_PT +: N_PT];
  end

  assign ct_o = claim_w & term_w[N_CT-1:0];
  assign fb_o = fb_lit_w;
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN  = 36,
  parameter int N_OUT = 16,
  parameter int N_FB  = 8,
  parameter int TOT   = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_shift_en,
  input logic             cfg_bit,
  input logic             cfg_load,
  input logic [N_IN-1:0]  in_i,
  input logic [N_OUT-1:0] out_o,
  input logic [N_FB-1:0]  fb_o,
  input logic [TOT-1:0]   shadow_w,
  input logic [TOT-1:0]   active_w,
  input logic [N_OUT-1:0] or_nonempty_w,
  input logic [N_FB-1:0]  fb_en_w
);
  // R7
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift_en |=> shadow_w[TOT-1] == $past(cfg_bit));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift_en |=> $stable(shadow_w));

  // R8
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> active_w == $past(shadow_w));

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(active_w));

  // R7
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> (!$stable(in_i) || $stable(out_o)));

  // R3
  empty_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_o & ~or_nonempty_w) == '0);

  // R6
  fb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_o | fb_en_w) == {N_FB{1'b1}});
endmodule

bind pla_array pla_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_FB(N_FB), .TOT(TOT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_shift_en  (cfg_shift_en),
  .cfg_bit       (cfg_bit),
  .cfg_load      (cfg_load),
  .in_i          (in_i),
  .out_o         (out_o),
  .fb_o          (fb_o),
  .shadow_w      (shadow_w),
  .active_w      (active_w),
  .or_nonempty_w (or_nonempty_w),
  .fb_en_w       (fb_en_w)
);

// File: tb/test_pla_array.sv
`timescale 1ns/1ps
module test_pla_array;
  localparam int NI  = 36;
  localparam int NP  = 48;
  localparam int NC  = 8;
  localparam int NF  = 8;
  localparam int NO  = 16;
  localparam int LW  = 2*NI + NF;
  localparam int ORB = NP*LW;
  localparam int CLB = ORB + NO*NP;
  localparam int FEB = CLB + NC;
  localparam int TOT = FEB + NF;
  localparam int FB0 = NP - NF;

  logic clk = 1'b0, rst_n = 1'b0, sh = 1'b0, sb = 1'b0, ld = 1'b0;
  logic [NI-1:0] inv = '0;
  logic [NO-1:0] out_w;
  logic [NC-1:0] ct_w;
  logic [NF-1:0] fb_w;

  pla_array i_pla_array (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(sh), .cfg_bit(sb), .cfg_load(ld),
    .in_i(inv), .out_o(out_w), .ct_o(ct_w), .fb_o(fb_w)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  bit cfgv[TOT];
  bit act[TOT];
  bit sq[$];
  logic [NO-1:0] e_out;
  logic [NC-1:0] e_ct;
  logic [NF-1:0] e_fb;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got %h exp %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // behavioural reference from the requirements
  task automatic model(input logic [NI-1:0] x);
    bit tv[NP];
    bit fbv[NF];
    bit v, ok, r;
    int p;
    for (int k = 0; k < NF; k++) begin
      p = FB0 + k;
      v = 1;
      for (int i = 0; i < NI; i++) begin
        if (act[p*LW+2*i] && !x[i]) v = 0;
        if (act[p*LW+2*i+1] && x[i]) v = 0;
      end
      tv[p] = v;
      fbv[k] = act[FEB+k] ? !v : 1'b1;
    end
    for (int q = 0; q < FB0; q++) begin
      v = 1;
      for (int i = 0; i < NI; i++) begin
        if (act[q*LW+2*i] && !x[i]) v = 0;
        if (act[q*LW+2*i+1] && x[i]) v = 0;
      end
      for (int k = 0; k < NF; k++)
        if (act[q*LW+2*NI+k] && !fbv[k]) v = 0;
      tv[q] = v;
    end
    for (int o = 0; o < NO; o++) begin
      r = 0;
      for (int q = 0; q < NP; q++) begin
        ok = 1;
        if (q < NC && act[CLB+q]) ok = 0;
        if (q >= FB0 && act[FEB+q-FB0]) ok = 0;
        if (ok && act[ORB+o*NP+q] && tv[q]) r = 1;
      end
      e_out[o] = r;
    end
    for (int c = 0; c < NC; c++) e_ct[c] = act[CLB+c] && tv[c];
    for (int k = 0; k < NF; k++) e_fb[k] = fbv[k];
  endtask

  function automatic logic [NI-1:0] rin();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[NI-1:0];
  endfunction

  // one cycle: drive, compare with model, take the edge, update model
  task automatic step(input bit s, input bit b, input bit l,
                      input logic [NI-1:0] x, input string tag);
    sh = s; sb = b; ld = l; inv = x;
    model(x);
    #1;
    chk(tag, "out", 64'(out_w), 64'(e_out));
    chk(tag, "ct",  64'(ct_w),  64'(e_ct));
    chk(tag, "fb",  64'(fb_w),  64'(e_fb));
    @(posedge clk);
    if (l) for (int j = 0; j < TOT; j++) act[j] = sq[j];
    if (s) begin sq.push_back(b); void'(sq.pop_front()); end
    #1;
  endtask

  // drive inputs with no strobe; caller checks, then calls tail()
  task automatic hold(input logic [NI-1:0] x);
    sh = 0; ld = 0; inv = x;
    #1;
  endtask

  task automatic tail();
    @(posedge clk);
    #1;
  endtask

  task automatic run(input int n, input string tag);
    for (int c = 0; c < n; c++) step(0, 0, 0, rin(), tag);
  endtask

  task automatic shift_all(input string tag);
    for (int j = 0; j < TOT; j++) step(1, cfgv[j], 0, rin(), tag);
    step(0, 0, 1, rin(), tag);
  endtask

  task automatic clear_cfg();
    for (int j = 0; j < TOT; j++) cfgv[j] = 0;
  endtask

  task automatic rand_cfg();
    for (int j = 0; j < ORB; j++) cfgv[j] = ($urandom_range(23) == 0);
    for (int j = ORB; j < CLB; j++) cfgv[j] = ($urandom_range(5) == 0);
    for (int j = CLB; j < TOT; j++) cfgv[j] = ($urandom_range(1) == 1);
  endtask

  function automatic logic [NI-1:0] ib(input int i);
    return NI'(1) << i;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < TOT; j++) begin sq.push_back(1'b0); act[j] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, checked by hand and against the model
    hold(rin());
    chk("R1", "out", 64'(out_w), 64'h0);
    chk("R1", "ct",  64'(ct_w),  64'h0);
    chk("R1", "fb",  64'(fb_w),  64'(8'hFF));
    tail();
    run(8, "R1");

    // R2 / R9: term 10 = in0 & ~in5 on out0, empty term 11 on out1, out2 empty
    clear_cfg();
    cfgv[10*LW + 0] = 1;
    cfgv[10*LW + 2*5+1] = 1;
    cfgv[ORB + 0*NP + 10] = 1;
    cfgv[ORB + 1*NP + 11] = 1;
    shift_all("R7");
    hold(ib(0));
    chk("R9", "out0 in0=1 in5=0", 64'(out_w[0]), 64'h1);
    chk("R2", "out1 empty term", 64'(out_w[1]), 64'h1);
    chk("R3", "out2 no term", 64'(out_w[2]), 64'h0);
    tail();
    hold(ib(0) | ib(5));
    chk("R2", "out0 in5=1", 64'(out_w[0]), 64'h0);
    tail();
    hold('0);
    chk("R2", "out0 in0=0", 64'(out_w[0]), 64'h0);
    tail();
    run(40, "R2");

    // R4: term 0 = in1 claimed, term 2 = in2 unclaimed, both picked by out3
    clear_cfg();
    cfgv[0*LW + 2*1] = 1;
    cfgv[2*LW + 2*2] = 1;
    cfgv[ORB + 3*NP + 0] = 1;
    cfgv[ORB + 3*NP + 2] = 1;
    cfgv[CLB + 0] = 1;
    shift_all("R7");
    hold(ib(1));
    chk("R4", "ct0 claimed", 64'(ct_w[0]), 64'h1);
    chk("R4", "out3 claimed term excluded", 64'(out_w[3]), 64'h0);
    tail();
    hold(ib(2));
    chk("R4", "out3 unclaimed term", 64'(out_w[3]), 64'h1);
    chk("R4", "ct2 unclaimed", 64'(ct_w[2]), 64'h0);
    tail();
    run(40, "R4");

    // R5 / R10: foldback 0 = nand(in2,in3), self bit set; term 12 = fb0 & in4
    clear_cfg();
    cfgv[FB0*LW + 2*2] = 1;
    cfgv[FB0*LW + 2*3] = 1;
    cfgv[FB0*LW + 2*NI + 0] = 1;
    cfgv[12*LW + 2*NI + 0] = 1;
    cfgv[12*LW + 2*4] = 1;
    cfgv[ORB + 5*NP + 12] = 1;
    cfgv[ORB + 6*NP + FB0] = 1;
    cfgv[FEB + 0] = 1;
    shift_all("R7");
    hold(ib(2) | ib(3) | ib(4));
    chk("R10", "fb0 ignores self literal", 64'(fb_w[0]), 64'h0);
    chk("R5", "out5 blocked by fb0", 64'(out_w[5]), 64'h0);
    chk("R5", "out6 enabled foldback excluded", 64'(out_w[6]), 64'h0);
    tail();
    hold(ib(3) | ib(4));
    chk("R5", "fb0 nand", 64'(fb_w[0]), 64'h1);
    chk("R5", "out5 via fb0", 64'(out_w[5]), 64'h1);
    tail();
    run(40, "R5");

    // R6: foldback 1 disabled, term 41 = in7 on out7, term 13 = fb1 only on out8
    clear_cfg();
    cfgv[(FB0+1)*LW + 2*7] = 1;
    cfgv[13*LW + 2*NI + 1] = 1;
    cfgv[ORB + 7*NP + FB0 + 1] = 1;
    cfgv[ORB + 8*NP + 13] = 1;
    shift_all("R7");
    hold('0);
    chk("R6", "fb1 disabled", 64'(fb_w[1]), 64'h1);
    chk("R6", "out7 in7=0", 64'(out_w[7]), 64'h0);
    chk("R6", "out8 neutral literal", 64'(out_w[8]), 64'h1);
    tail();
    hold(ib(7));
    chk("R6", "out7 ordinary term", 64'(out_w[7]), 64'h1);
    chk("R6", "out8 neutral literal", 64'(out_w[8]), 64'h1);
    tail();
    run(20, "R6");

    // R3: random sparse configurations
    for (int n = 0; n < 6; n++) begin
      rand_cfg();
      shift_all("R7");
      run(40, "R3");
    end

    // R8: load together with the last shift, then load again
    rand_cfg();
    for (int j = 0; j < TOT-1; j++) step(1, cfgv[j], 0, rin(), "R7");
    step(1, cfgv[TOT-1], 1, rin(), "R8");
    run(20, "R8");
    step(0, 0, 1, rin(), "R8");
    run(20, "R8");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule